// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns 32 asynchronous external pins into interrupt requests for the core clock domain. Each pin first passes through a two-stage synchroniser. A per-pin trigger selector then turns the synchronised value into a detection event. Five trigger kinds are available: a high level, a low level, a rising edge, a falling edge, or either edge.

Each detection latches a pending flag, and software clears the flag with a write-one-to-clear access. A per-pin mask bit decides whether a pending flag reaches the interrupt outputs. The lower sixteen pins each own one output line. The upper sixteen pins are ORed onto a single shared line.

The pins are grouped into banks of eight. Each bank has three 32-bit registers on a simple single-cycle register bus:
- a trigger configuration word,
- a mask word,
- a pending word.

Writes take effect on the clock edge. Reads are combinational from the word index.

Top module: `eint_ctrl`

## Requirements
- R1: While reset is held, every mask word reads 0x000000FF, every pending word reads 0, every configuration word reads 0, and all interrupt outputs are low.
- R2: The configuration word of bank b sits at word index b (0..3) and holds, for pin j of the bank, a 3-bit trigger field at bits 4j+2..4j. Bit 4j+3 and any bit above the fields reads 0. Field codes are 000 low level, 001 high level, 010 falling edge, 011 rising edge, and 1xx either edge.
- R3: With code 011, a low-to-high change on the pin sets its pending bit, and a high-to-low change does not.
- R4: With code 010, a high-to-low change on the pin sets its pending bit, and a low-to-high change does not.
- R5: With any code 1xx, both a rising and a falling change on the pin set its pending bit.
- R6: With code 000, the pending bit is set on every cycle the synchronised pin is low, so a clear has no effect while the level lasts.
- R7: With code 001, the pending bit is set on every cycle the synchronised pin is high, so a clear has no effect while the level lasts.
- R8: The pending word of bank b sits at word index 8+b, with pin j at bit j. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: The mask word of bank b sits at word index 4+b, with pin j at bit j, where 1 means masked. Pending bits are set whatever the mask says. An output is driven only for pins that are pending and unmasked, and masking a pending pin drops its output without clearing the pending bit.
- R10: For pins 0..15, output bit irq_direct[n] is high exactly when pin n is pending and unmasked. No other pin affects it.
- R11: irq_shared is high exactly when at least one of pins 16..31 is pending and unmasked.
- R12: A pin change driven between clock edges shows in its pending bit after the third rising clock edge, and not after the second.
- R13: Word indices 12..15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe, committed on the rising clock edge |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_direct | output | 16 | One interrupt line for each of pins 0..15 |
| irq_shared | output | 1 | Combined interrupt line for pins 16..31 |

## Verification
A wrong trigger field, a pending bit that clears too readily, or a pending bit stuck high shows on the interrupt outputs and in the pending word on the third clock edge after the pin moves. That is the same cycle the correct design reacts, so every check samples exactly there and one edge earlier. A mask or routing error shows as an output line that belongs to a different pin, or as an output that does not follow the mask word on the edge the mask is written. The bench therefore sweeps every pin against every field code and compares all output lines each time, not only the line of the pin under test.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int BANK_PINS    = 8;
    localparam int MODE_W       = 3;
    localparam int FIELD_STRIDE = 4;
    localparam int KIND_W       = 2;

    // Low two bits of a trigger field when its top bit is clear.
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_base_e;

    // Register class, taken from the upper bits of the word index.
    typedef enum logic [KIND_W-1:0] {
        REG_CFG  = 2'd0,
        REG_MASK = 2'd1,
        REG_PEND = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [BANK_PINS-1:0][MODE_W-1:0] cfg;
        logic [BANK_PINS-1:0]             mask;
        logic [BANK_PINS-1:0]             pend;
        logic [BANK_PINS-1:0]             prev;
    } bank_state_t;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/eint_trigger.sv
module eint_trigger
    import eint_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cur_i,
    input  logic              prev_i,
    output logic              hit_o
);

    always_comb begin
        if (mode_i[MODE_W-1]) begin
            // Any code with the top bit set means either edge.
            hit_o = cur_i ^ prev_i;
        end else begin
            unique case (trig_base_e'(mode_i[1:0]))
                TRIG_LOW:  hit_o = ~cur_i;
                TRIG_HIGH: hit_o = cur_i;
                TRIG_FALL: hit_o = ~cur_i & prev_i;
                TRIG_RISE: hit_o = cur_i & ~prev_i;
                default:   hit_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eint_bank.sv
module eint_bank
    import eint_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_PINS-1:0] pin_s_i,
    input  logic                 cfg_we_i,
    input  logic                 mask_we_i,
    input  logic                 pend_we_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    cfg_rd_o,
    output logic [BANK_PINS-1:0] mask_o,
    output logic [BANK_PINS-1:0] pend_o,
    output logic [BANK_PINS-1:0] req_o
);

    bank_state_t          st_d, st_q;
    logic [BANK_PINS-1:0] hit;
    logic [BANK_PINS-1:0] clr;
    logic [BANK_PINS-1:0] unused_gap_bits;

    for (genvar g = 0; g < BANK_PINS; g++) begin : g_pin
        eint_trigger u_trig (
            .mode_i (st_q.cfg[g]),
            .cur_i  (pin_s_i[g]),
            .prev_i (st_q.prev[g]),
            .hit_o  (hit[g])
        );
        assign unused_gap_bits[g] = wdata_i[g*FIELD_STRIDE + MODE_W];

        assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[g] == 3'b011 && pin_s_i[g] && !st_q.prev[g]) |=> st_q.pend[g])
            else $error("rising edge lost on bank pin %0d", g);

        assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[g] == 3'b000 && !pin_s_i[g]) |=> st_q.pend[g])
            else $error("active low level did not hold pending on pin %0d", g);

        assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !(pend_we_i && wdata_i[g])) |=> st_q.pend[g])
            else $error("pending bit %0d dropped without a one written", g);

        assert_pend_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[g]) |-> $past(hit[g]))
            else $error("pending bit %0d set with no trigger event", g);
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_s_i;
        if (cfg_we_i) begin
            for (int k = 0; k < BANK_PINS; k++) begin
                st_d.cfg[k] = wdata_i[k*FIELD_STRIDE +: MODE_W];
            end
        end
        if (mask_we_i) begin
            st_d.mask = wdata_i[BANK_PINS-1:0];
        end
        clr       = pend_we_i ? wdata_i[BANK_PINS-1:0] : '0;
        // A new event wins over a clear in the same cycle.
        st_d.pend = (st_q.pend & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rd_o = '0;
        for (int k = 0; k < BANK_PINS; k++) begin
            cfg_rd_o[k*FIELD_STRIDE +: MODE_W] = st_q.cfg[k];
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign req_o  = st_q.pend & ~st_q.mask;

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int DIRECT_PINS = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_BANKS  = NUM_PINS / BANK_PINS,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int ADDR_W     = BANK_W + KIND_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PINS-1:0]    pins_i,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [DIRECT_PINS-1:0] irq_direct,
    output logic                   irq_shared
);

    logic [NUM_PINS-1:0]                  pins_s;
    logic [NUM_BANKS-1:0][DATA_W-1:0]     cfg_rd;
    logic [NUM_BANKS-1:0][BANK_PINS-1:0]  mask_v;
    logic [NUM_BANKS-1:0][BANK_PINS-1:0]  pend_v;
    logic [NUM_BANKS-1:0][BANK_PINS-1:0]  req_v;
    logic [NUM_PINS-1:0]                  req_all;
    reg_kind_e                            kind;
    logic [BANK_W-1:0]                    bank_sel;

    assign kind     = reg_kind_e'(bus_addr[ADDR_W-1 -: KIND_W]);
    assign bank_sel = bus_addr[BANK_W-1:0];

    eint_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pins_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = bus_we && (bank_sel == BANK_W'(b));

        eint_bank #(
            .DATA_W (DATA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s_i   (pins_s[b*BANK_PINS +: BANK_PINS]),
            .cfg_we_i  (sel && kind == REG_CFG),
            .mask_we_i (sel && kind == REG_MASK),
            .pend_we_i (sel && kind == REG_PEND),
            .wdata_i   (bus_wdata),
            .cfg_rd_o  (cfg_rd[b]),
            .mask_o    (mask_v[b]),
            .pend_o    (pend_v[b]),
            .req_o     (req_v[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (kind)
            REG_CFG:  bus_rdata = cfg_rd[bank_sel];
            REG_MASK: bus_rdata[BANK_PINS-1:0] = mask_v[bank_sel];
            REG_PEND: bus_rdata[BANK_PINS-1:0] = pend_v[bank_sel];
            default:  bus_rdata = '0;
        endcase
    end

    assign req_all    = req_v;
    assign irq_direct = req_all[DIRECT_PINS-1:0];
    assign irq_shared = |req_all[NUM_PINS-1:DIRECT_PINS];

endmodule

// File: tb/eint_ctrl_test.sv
`timescale 1ns/1ps
module eint_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] irq_direct;
    logic        irq_shared;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    eint_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected outputs when pin p alone is pending and unmasked (on=1) or nothing is.
    task automatic check_out(input string tag, input int p, input bit on);
        logic [15:0] ed;
        logic        es;
        ed = (on && p < 16) ? (16'h1 << p) : 16'h0;
        es = on && p >= 16;
        check({tag, " direct"}, {16'h0, irq_direct}, {16'h0, ed});
        check({tag, " shared"}, {31'h0, irq_shared}, {31'h0, es});
    endtask

    function automatic string mtag(input int m);
        if (m >= 4) return "R5";
        case (m)
            0: return "R6";
            1: return "R7";
            2: return "R4";
            default: return "R3";
        endcase
    endfunction

    initial begin
        logic [31:0] v;
        pins = '1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: register and output values while reset is held
        for (int b = 0; b < 4; b++) begin
            rd(4'(b), v);     check($sformatf("R1 cfg bank%0d", b), v, 32'h0);
            rd(4'(4 + b), v); check($sformatf("R1 mask bank%0d", b), v, 32'hFF);
            rd(4'(8 + b), v); check($sformatf("R1 pend bank%0d", b), v, 32'h0);
        end
        check_out("R1 outputs", 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        edges(5);
        for (int b = 0; b < 4; b++) wr(4'(8 + b), 32'hFF);

        // R2 field layout and R13 unmapped words
        for (int b = 0; b < 4; b++) begin
            wr(4'(b), 32'hFFFF_FFFF);
            rd(4'(b), v); check($sformatf("R2 all-ones bank%0d", b), v, 32'h7777_7777);
            wr(4'(b), 32'h89AB_CDEF ^ (32'h1111_1111 * b));
            rd(4'(b), v);
            check($sformatf("R2 pattern bank%0d", b), v, (32'h89AB_CDEF ^ (32'h1111_1111 * b)) & 32'h7777_7777);
        end
        for (int a = 12; a < 16; a++) begin
            wr(4'(a), 32'hFFFF_FFFF);
            rd(4'(a), v); check($sformatf("R13 read word%0d", a), v, 32'h0);
        end
        for (int b = 0; b < 4; b++) begin
            rd(4'(b), v);
            check($sformatf("R13 cfg kept bank%0d", b), v, (32'h89AB_CDEF ^ (32'h1111_1111 * b)) & 32'h7777_7777);
            rd(4'(4 + b), v); check($sformatf("R13 mask kept bank%0d", b), v, 32'hFF);
            wr(4'(b), 32'h0);
        end
        edges(4);
        for (int b = 0; b < 4; b++) wr(4'(8 + b), 32'hFF);

        // Sweep of every pin against every trigger code
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 8; m++) begin
                int    b;
                int    i;
                bit    lvl;
                bit    idle;
                string t;
                b = p / 8; i = p % 8;
                lvl  = (m < 2);
                idle = (m == 0 || m == 2);
                t = $sformatf("%s pin%0d code%0d", mtag(m), p, m);
                pins[p] = idle;
                edges(4);
                wr(4'(b), 32'(m) << (4 * i));
                wr(4'(8 + b), 32'hFF);
                rd(4'(8 + b), v); check({t, " cleared"}, v, 32'h0);
                wr(4'(4 + b), 32'(8'hFF & ~(8'h1 << i)));
                check_out({t, " idle"}, p, 1'b0);
                pins[p] = ~idle;
                edges(2);
                rd(4'(8 + b), v); check({"R12 ", t, " early"}, v, 32'h0);
                edges(1);
                rd(4'(8 + b), v); check({t, " set"}, v, 32'h1 << i);
                check_out({"R10 R11 ", t}, p, 1'b1);
                if (lvl) begin
                    wr(4'(8 + b), 32'h1 << i);
                    rd(4'(8 + b), v); check({t, " clear while active"}, v, 32'h1 << i);
                    pins[p] = idle;
                    edges(3);
                    wr(4'(8 + b), 32'h1 << i);
                    rd(4'(8 + b), v); check({t, " clear after level"}, v, 32'h0);
                    check_out({t, " after clear"}, p, 1'b0);
                end else begin
                    wr(4'(8 + b), 32'h0);
                    rd(4'(8 + b), v); check({"R8 ", t, " zero write"}, v, 32'h1 << i);
                    wr(4'(4 + b), 32'hFF);
                    check_out({"R9 ", t, " masked"}, p, 1'b0);
                    rd(4'(8 + b), v); check({"R9 ", t, " pend kept"}, v, 32'h1 << i);
                    wr(4'(4 + b), 32'(8'hFF & ~(8'h1 << i)));
                    check_out({"R9 ", t, " unmasked"}, p, 1'b1);
                    wr(4'(8 + b), 32'h1 << i);
                    rd(4'(8 + b), v); check({"R8 ", t, " one write"}, v, 32'h0);
                    check_out({"R8 ", t, " out"}, p, 1'b0);
                    pins[p] = idle;
                    edges(3);
                    rd(4'(8 + b), v);
                    check({t, " return edge"}, v, (m >= 4) ? (32'h1 << i) : 32'h0);
                end
                wr(4'(b), 32'h0);
                pins[p] = 1'b1;
                edges(4);
                wr(4'(4 + b), 32'hFF);
                wr(4'(8 + b), 32'hFF);
            end
        end

        // R11: shared line stays up until the last shared source is cleared
        wr(4'd2, 32'h3);
        wr(4'd3, 32'h3 << 4);
        pins[16] = 1'b0; pins[25] = 1'b0;
        edges(4);
        wr(4'd10, 32'hFF); wr(4'd11, 32'hFF);
        wr(4'd6, 32'hFE); wr(4'd7, 32'hFD);
        pins[16] = 1'b1; pins[25] = 1'b1;
        edges(3);
        check("R11 two sources", {31'h0, irq_shared}, 32'h1);
        wr(4'd10, 32'h1);
        check("R11 one source left", {31'h0, irq_shared}, 32'h1);
        wr(4'd11, 32'h2);
        check("R11 none left", {31'h0, irq_shared}, 32'h0);
        check("R10 direct quiet", {16'h0, irq_direct}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule